// File: doc/BRIEF.md
# Sinc-Weighted Tap-Sum Noise Filter

This block turns the parallel stage outputs of a pseudo-random bit shift register into a multi-bit signed noise sample. It adds no delay line of its own. The sixteen stages of the generator register already hold the last sixteen sequence bits, so they act as the taps of a low-pass FIR filter. Each tap bit counts as +1 when it is one and as -1 when it is zero. That value is scaled by a fixed signed coefficient, and the coefficients follow a sin(x)/x profile centred between the middle two stages. Taps with positive coefficients go into one accumulator and taps with negative coefficients go into another. The filter output is the positive accumulator minus the negative one.

The generator feeds the block its 16-bit stage vector together with a valid strobe on every shift. The filter returns one registered sample for each strobe. The cutoff frequency is tied to the shift clock, and the passband edge falls near 5% of that rate. Below about a tenth of the clock rate the raw bit stream has a nearly flat spectrum, so the filtered samples come close to band-limited white noise. The samples can go to a DAC or to a digital test path.

Top module: `sinc_tap_filter`

## Requirements
- R1: One clock edge after a cycle with `inValid` high, `sampleOut` equals the sum over taps i of c[i]*s[i], where s[i] is +1 if `tapsIn[i]` is 1 and -1 if it is 0.
- R2: Taps are mapped to ±1 and not to 0/1. The all-ones vector gives +502, the all-zeros vector gives -502, and setting a single tap i to one in an otherwise zero vector gives -502 + 2*c[i].
- R3: The coefficients at bit positions 3 and 12 are zero. Changing only those bits leaves `sampleOut` unchanged.
- R4: `outValid` equals `inValid` delayed by exactly one clock. In a cycle with `inValid` low, `sampleOut` keeps its value whatever `tapsIn` holds.
- R5: While `rstN` is low (asynchronous, active low), `sampleOut` is 0 and `outValid` is 0.
- R6: The output is 13 bits signed, which is wide enough for the worst case. Vector 0x0FF0 gives +766 and vector 0xF00F gives -766, with no wrap-around.
- R7: The default coefficients, listed by bit index 0 to 15, are -20, -26, -20, 0, 32, 68, 99, 118, 118, 99, 68, 32, 0, -20, -26, -20. They are symmetric, so c[i] = c[15-i], and a vector and its bit-reversal give the same sample.
- R8: The input is driven with a 15-stage XNOR maximal-length sequence (feedback from stages 15 and 14, starting at all zeros), where bit 15 is the previous bit 14. Over 32767 consecutive samples, the magnitude of the output sum is at most 32767, which means the mean is within one coefficient unit of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tapsIn | input | 16 | Parallel stage outputs of the bit generator, bit i = stage i |
| inValid | input | 1 | Tap vector is valid this cycle |
| sampleOut | output | 13 | Signed filtered sample (two's complement) |
| outValid | output | 1 | sampleOut was updated at the last edge |

## Verification
The hardest condition to reach from the ports is the statistical property in R8: the output has a near-zero mean over a whole sequence period. This holds only when the tap vector moves through every state of a real maximal-length sequence and none is skipped. The bench therefore runs its own XNOR generator for all 32767 states and feeds each window in with `inValid` held high. It checks every sample against a weighted-sum model and totals the samples. The zero-weight taps are driven separately with vectors that differ only at bits 3 and 12.

// File: rtl/snf_pkg.sv
package snf_pkg;

  // Strobes the control path sends to the datapath
  typedef struct packed {
    logic capture;   // register a new sample this edge
  } snfStrobes_t;

  // Default sinc profile, bit index 15 down to 0 (symmetric, so order is moot)
  localparam logic signed [15:0][7:0] SINC_COEFS_16 = '{
    -8'sd20, -8'sd26, -8'sd20, 8'sd0, 8'sd32, 8'sd68, 8'sd99, 8'sd118,
    8'sd118, 8'sd99, 8'sd68, 8'sd32, 8'sd0, -8'sd20, -8'sd26, -8'sd20
  };

  // Accumulator width that holds numTaps * max|coef| with sign
  function automatic int accWidth(input int coefW, input int numTaps);
    return coefW + $clog2(numTaps) + 1;
  endfunction

endpackage

// File: rtl/snf_ctrl.sv
module snf_ctrl (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  output snf_pkg::snfStrobes_t  strobes,
  output logic                  outValid
);

  always_comb begin
    strobes.capture = inValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R4: valid follows the input strobe with one cycle of latency
  a_r4_valid_follow: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r4_valid_drop: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R5: reset clears the valid flag
  a_r5_reset_valid: assert property (@(posedge clk)
    !rstN |=> !outValid);

endmodule

// File: rtl/snf_datapath.sv
module snf_datapath #(
  parameter int NUM_TAPS = 16,
  parameter int COEF_W   = 8,
  parameter int ACC_W    = snf_pkg::accWidth(COEF_W, NUM_TAPS),
  parameter logic signed [NUM_TAPS-1:0][COEF_W-1:0] COEFS = snf_pkg::SINC_COEFS_16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  snf_pkg::snfStrobes_t        strobes,
  input  logic [NUM_TAPS-1:0]         taps,
  output logic signed [ACC_W-1:0]     sampleQ
);

  // Total of magnitudes on one side of the sign split
  function automatic int sideMag(input bit wantNeg);
    int acc = 0;
    for (int k = 0; k < NUM_TAPS; k++) begin
      int c = int'($signed(COEFS[k]));
      if (wantNeg && c < 0)       acc += -c;
      else if (!wantNeg && c > 0) acc += c;
    end
    return acc;
  endfunction

  function automatic int coefTotal();
    int acc = 0;
    for (int k = 0; k < NUM_TAPS; k++) acc += int'($signed(COEFS[k]));
    return acc;
  endfunction

  localparam int POS_MAG = sideMag(1'b0);
  localparam int NEG_MAG = sideMag(1'b1);
  localparam logic signed [ACC_W-1:0] ALL_ONES_SUM = ACC_W'(coefTotal());

  logic signed [ACC_W-1:0] posTerm [NUM_TAPS];
  logic signed [ACC_W-1:0] negTerm [NUM_TAPS];
  logic signed [ACC_W-1:0] posSum, negSum, sampleD;

  // Per-tap ±1 mapping and routing to the accumulator that matches the sign
  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    localparam int CI = int'($signed(COEFS[i]));
    localparam logic signed [ACC_W-1:0] MAG = ACC_W'((CI < 0) ? -CI : CI);
    if (CI >= 0) begin : g_pos
      always_comb begin
        posTerm[i] = taps[i] ? MAG : -MAG;
        negTerm[i] = '0;
      end
    end else begin : g_neg
      always_comb begin
        negTerm[i] = taps[i] ? MAG : -MAG;
        posTerm[i] = '0;
      end
    end
  end

  always_comb begin
    posSum = '0;
    negSum = '0;
    for (int k = 0; k < NUM_TAPS; k++) begin
      posSum += posTerm[k];
      negSum += negTerm[k];
    end
    sampleD = posSum - negSum;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                sampleQ <= '0;
    else if (strobes.capture) sampleQ <= sampleD;
  end

  // R6: neither accumulator leaves its worst-case range
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (int'(posSum) <= POS_MAG) && (int'(posSum) >= -POS_MAG) &&
    (int'(negSum) <= NEG_MAG) && (int'(negSum) >= -NEG_MAG));
  // R4: sample holds when no new vector arrives
  a_r4_hold_sample: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(sampleQ));
  // R2: extreme vectors give plus and minus the coefficient total
  a_r2_all_ones: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && (&taps)) |=> (sampleQ == ALL_ONES_SUM));
  a_r2_all_zeros: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && (taps == '0)) |=> (sampleQ == -ALL_ONES_SUM));

endmodule

// File: rtl/sinc_tap_filter.sv
module sinc_tap_filter #(
  parameter int NUM_TAPS = 16,
  parameter int COEF_W   = 8,
  parameter logic signed [NUM_TAPS-1:0][COEF_W-1:0] COEFS = snf_pkg::SINC_COEFS_16,
  localparam int ACC_W   = snf_pkg::accWidth(COEF_W, NUM_TAPS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_TAPS-1:0]     tapsIn,
  input  logic                    inValid,
  output logic signed [ACC_W-1:0] sampleOut,
  output logic                    outValid
);

  snf_pkg::snfStrobes_t strobes;

  snf_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  snf_datapath #(
    .NUM_TAPS (NUM_TAPS),
    .COEF_W   (COEF_W),
    .ACC_W    (ACC_W),
    .COEFS    (COEFS)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .taps    (tapsIn),
    .sampleQ (sampleOut)
  );

endmodule

// File: tb/sinc_tap_filter_tb.sv
`timescale 1ns/1ps
module sinc_tap_filter_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] tapsIn = '0;
  logic inValid = 1'b0;
  logic signed [12:0] sampleOut;
  logic outValid;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sinc_tap_filter dut_i (
    .clk(clk), .rstN(rstN), .tapsIn(tapsIn), .inValid(inValid),
    .sampleOut(sampleOut), .outValid(outValid)
  );

  // Coefficients from R7, bit index 0..15
  localparam int COEF [16] = '{-20, -26, -20, 0, 32, 68, 99, 118,
                               118, 99, 68, 32, 0, -20, -26, -20};

  function automatic int model(input logic [15:0] v);
    int acc = 0;
    for (int k = 0; k < 16; k++) acc += v[k] ? COEF[k] : -COEF[k];
    return acc;
  endfunction

  typedef struct packed {
    logic [15:0]  vec;
    int           expV;
    logic [23:0]  tag;
  } vecEntry_t;

  localparam int NVEC = 14;
  localparam vecEntry_t VECS [NVEC] = '{
    '{16'h0000, -502, "R2 "},   // all zeros
    '{16'hFFFF,  502, "R2 "},   // all ones
    '{16'h0FF0,  766, "R6 "},   // positive extreme
    '{16'hF00F, -766, "R6 "},   // negative extreme
    '{16'h0080, -266, "R1 "},   // centre tap
    '{16'h0001, -542, "R1 "},   // edge tap
    '{16'h0008, -502, "R3 "},   // zero tap 3
    '{16'h1000, -502, "R3 "},   // zero tap 12
    '{16'hFFF7,  502, "R3 "},   // ones except zero tap 3
    '{16'h0002, -554, "R7 "},   // tap 1
    '{16'h4000, -554, "R7 "},   // mirror tap 14
    '{16'h00F0,  132, "R7 "},   // lower centre half
    '{16'h0F00,  132, "R7 "},   // mirrored half
    '{16'h0010, -438, "R1 "}    // tap 4
  };

  task automatic check(input string tag, input int act, input int expV);
    checks++;
    if (act != expV) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expV);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] r16;
    int prevExp, act, mism, sum;
    // R5: reset state
    repeat (3) @(negedge clk);
    check("R5 sample in reset", int'(sampleOut), 0);
    check("R5 valid in reset", int'(outValid), 0);
    rstN = 1'b1;

    // Table walk: one vector per cycle, check one edge later (R1, R4)
    for (int n = 0; n < NVEC; n++) begin
      @(negedge clk);
      tapsIn = VECS[n].vec;
      inValid = 1'b1;
      @(negedge clk);
      check($sformatf("%s vec %h", VECS[n].tag, VECS[n].vec),
            int'(sampleOut), VECS[n].expV);
      check("R4 valid latency", int'(outValid), 1);
    end

    // R4: hold while inValid low
    @(negedge clk);
    tapsIn = 16'h0FF0; inValid = 1'b1;
    @(negedge clk);
    tapsIn = 16'hF00F; inValid = 1'b0;
    @(negedge clk);
    check("R4 hold sample", int'(sampleOut), 766);
    check("R4 valid low", int'(outValid), 0);
    @(negedge clk);
    check("R4 still held", int'(sampleOut), 766);

    // R3: toggling only bits 3 and 12 leaves the sample unchanged
    tapsIn = 16'h5A5A & 16'hEFF7; inValid = 1'b1;
    @(negedge clk);
    prevExp = int'(sampleOut);
    tapsIn = (16'h5A5A & 16'hEFF7) | 16'h1008;
    @(negedge clk);
    check("R3 zero taps toggled", int'(sampleOut), prevExp);

    // R7: a vector and its bit-reversal agree
    tapsIn = 16'h0137;
    @(negedge clk);
    prevExp = int'(sampleOut);
    tapsIn = {<<{16'h0137}};
    @(negedge clk);
    check("R7 bit-reversal symmetry", int'(sampleOut), prevExp);
    check("R1 model 0x0137", prevExp, model(16'h0137));

    // R8: full XNOR maximal-length period
    r16 = '0;
    for (int w = 0; w < 40; w++) r16 = {r16[14:0], ~(r16[14] ^ r16[13])};
    mism = 0; sum = 0;
    tapsIn = r16; prevExp = model(r16);
    for (int n = 0; n < 32767; n++) begin
      r16 = {r16[14:0], ~(r16[14] ^ r16[13])};
      @(negedge clk);
      act = int'(sampleOut);
      if (act != prevExp) mism++;
      sum += act;
      tapsIn = r16;
      prevExp = model(r16);
    end
    inValid = 1'b0;
    check("R1 sequence samples mismatching", mism, 0);
    check("R8 period sum within bound", (sum <= 32767 && sum >= -32767) ? 1 : 0, 1);

    // R5: reset mid-run clears outputs asynchronously
    @(negedge clk);
    tapsIn = 16'hFFFF; inValid = 1'b1;
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R5 sample after async reset", int'(sampleOut), 0);
    check("R5 valid after async reset", int'(outValid), 0);
    @(negedge clk);
    inValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule